// File: doc/BRIEF.md
# Quad-SPI Instruction Word Fetcher

This block sits between a processor core and an external serial NOR flash that holds program memory. After reset it brings the flash up without help from the core. It sends a fixed script of single-line command frames, and the last of these sets the quad-enable bit in the flash's status register. From then on it serves 16-bit word reads, for instruction fetch and for table lookups, using the flash's quad I/O fast-read command. Each word is fetched in its own chip-select frame.

The core presents a 14-bit word address with a valid strobe. The fetcher takes the request in any cycle where it is not busy. It returns the word with a one-cycle valid pulse. The busy output stalls the core during start-up and while a read is in flight.

On the flash side the block drives chip select and a serial clock at half the system clock, using SPI mode 0. The four data lines are brought out as separate output, output-enable and input vectors, so that a tristate pad can be placed outside the block. A direction pin steers an external bidirectional level shifter, and the block turns that pin around between its last driven nibble and the first nibble the flash returns.

Top module: `qspi_word_fetch`

## Requirements
- R1: While reset (active low) is asserted: chip select is high, the serial clock is low, no data line is enabled, the direction pin is high, busy is high and no response is valid.
- R2: After reset the block sends four single-line frames, each under its own chip-select low period, in this order: {0xFF}, {0xAB}, {0x06}, {0x01, 0x02, 0x02}. Bits go out most significant first on data line 0, and only data line 0 is enabled (output enable = 4'b0001) during these frames.
- R3: Busy stays high from reset until the start-up script is complete, and again from the accepting edge of a request until its frame has closed. A request is taken only on a clock edge where valid is high and busy is low. A request raised only while busy starts no frame and produces no response. Chip select is never low while busy is low.
- R4: A read frame sends 0xEB on data line 0, one bit per clock. It then drives all four lines, high nibble first, with the bytes 0x00, 0x00, B[23:16], B[15:8], B[7:0], 0x00, 0xA5, where the byte address B is twice the word address.
- R5: The direction pin is low exactly when at least one data line is enabled. Inside a read frame it goes high on the serial clock falling edge that follows the 0xA5 low nibble, before the flash places its first data nibble. The block never enables a line while the flash is driving.
- R6: Four nibbles are sampled on successive rising serial clock edges after the turnaround. The returned word is {first byte, second byte}, and each byte is assembled from its high nibble first.
- R7: The serial clock idles low, toggles only while chip select is low, and is high for exactly one system clock at a time. Output data and enables change only while the serial clock is low.
- R8: Each accepted request produces exactly one read frame. Chip select is high for at least one system clock between any two frames.
- R9: The response valid pulse lasts one clock. It appears 53 clocks after the clock in which the request was seen with busy low, in the same clock in which chip select returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Word read request |
| reqAddr | input | 14 | Word address of the request |
| busy | output | 1 | Start-up or read in progress; new requests are ignored |
| rspValid | output | 1 | One-cycle pulse, rspData holds the fetched word |
| rspData | output | 16 | Fetched word, first flash byte in the upper half |
| flashCsN | output | 1 | Flash chip select, active low |
| flashSck | output | 1 | Flash serial clock |
| ioOut | output | 4 | Values driven on the four data lines |
| ioOe | output | 4 | Per-line output enable |
| ioIn | input | 4 | Values read back from the four data lines |
| busDir | output | 1 | Level shifter direction: low drives toward the flash, high receives |

## Verification
The bench puts a behavioural flash on the pins. The flash decodes every frame, returns data from a computed memory image, and flags any cycle in which both sides drive the lines. A turnaround placed one edge late would therefore show up as a collision, and one placed one edge early would corrupt the 0xA5 byte. The bench requests the lowest and the highest word address, so a missing doubling or a misplaced address byte changes the decoded frame. It also issues back-to-back requests with valid held high, and stray requests raised only while busy, both during start-up and during a read. A fetcher that latched a request while busy would then produce an extra frame or an extra response. Nibble or byte order errors change the returned word, and an off-by-one in the beat count moves the response pulse away from its expected clock.

// File: rtl/qfetch_pkg.sv
package qfetch_pkg;

  localparam int BEAT_W      = 5;
  localparam int INIT_FRAMES = 4;
  localparam int SHORT_LAST  = 7;    // last beat of a one-byte script frame
  localparam int LONG_LAST   = 23;   // last beat of the three-byte script frame
  localparam int CMD_BEATS   = 8;    // single-line opcode beats in a read
  localparam int QIN_FIRST   = 22;   // first beat the flash drives
  localparam int READ_LAST   = 25;   // last beat of a read frame

  localparam logic [7:0] OP_QREAD  = 8'hEB;
  localparam logic [7:0] MODE_BYTE = 8'hA5;

  typedef enum logic [1:0] {
    LANE_NONE,
    LANE_SINGLE,
    LANE_QOUT,
    LANE_QIN
  } lane_e;

  typedef struct packed {
    logic              latchAddr;
    logic              shiftIn;
    logic              pushWord;
    lane_e             lane;
    logic [BEAT_W-1:0] beat;
    logic [1:0]        frameSel;
    logic              readFrame;
  } strobe_t;

  function automatic logic [7:0] scriptByte(input logic [1:0] frame, input logic [1:0] idx);
    case (frame)
      2'd0:    scriptByte = 8'hFF;
      2'd1:    scriptByte = 8'hAB;
      2'd2:    scriptByte = 8'h06;
      default: scriptByte = (idx == 2'd0) ? 8'h01 : 8'h02;
    endcase
  endfunction

endpackage

// File: rtl/qfetch_ctrl.sv
module qfetch_ctrl
  import qfetch_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    busy,
  output logic    csN,
  output logic    sck,
  output strobe_t stb
);

  localparam int GW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);

  typedef enum logic [1:0] {S_GAP, S_INIT, S_IDLE, S_READ} state_e;

  state_e            state;
  logic [BEAT_W-1:0] beat;
  logic              phase;
  logic [1:0]        frameIdx;
  logic              initDone;
  logic [GW-1:0]     gapCnt;
  logic              lastBeat;
  logic              active;

  assign active = (state == S_INIT) || (state == S_READ);

  always_comb begin
    if (state == S_READ)
      lastBeat = (beat == BEAT_W'(READ_LAST));
    else if (frameIdx == 2'(INIT_FRAMES - 1))
      lastBeat = (beat == BEAT_W'(LONG_LAST));
    else
      lastBeat = (beat == BEAT_W'(SHORT_LAST));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_GAP;
      beat     <= '0;
      phase    <= 1'b0;
      frameIdx <= '0;
      initDone <= 1'b0;
      gapCnt   <= '0;
    end else begin
      case (state)
        S_GAP: begin
          if (gapCnt == GW'(GAP_CYCLES - 1)) begin
            gapCnt <= '0;
            beat   <= '0;
            phase  <= 1'b0;
            state  <= initDone ? S_IDLE : S_INIT;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        S_IDLE: begin
          if (reqValid) begin
            state <= S_READ;
            beat  <= '0;
            phase <= 1'b0;
          end
        end
        default: begin
          phase <= ~phase;
          if (phase) begin
            if (lastBeat) begin
              phase <= 1'b0;
              state <= S_GAP;
              if (state == S_INIT) begin
                frameIdx <= frameIdx + 1'b1;
                if (frameIdx == 2'(INIT_FRAMES - 1)) initDone <= 1'b1;
              end
            end else begin
              beat <= beat + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign csN  = !active;
  assign sck  = phase;

  always_comb begin
    stb           = '0;
    stb.beat      = beat;
    stb.frameSel  = frameIdx;
    stb.readFrame = (state == S_READ);
    stb.latchAddr = (state == S_IDLE) && reqValid;
    stb.shiftIn   = (state == S_READ) && !phase && (beat >= BEAT_W'(QIN_FIRST));
    stb.pushWord  = (state == S_READ) && phase && (beat == BEAT_W'(READ_LAST));
    if (state == S_INIT)
      stb.lane = LANE_SINGLE;
    else if (state == S_READ) begin
      if (beat < BEAT_W'(CMD_BEATS))      stb.lane = LANE_SINGLE;
      else if (beat < BEAT_W'(QIN_FIRST)) stb.lane = LANE_QOUT;
      else                                stb.lane = LANE_QIN;
    end else
      stb.lane = LANE_NONE;
  end

endmodule

// File: rtl/qfetch_dpath.sv
module qfetch_dpath
  import qfetch_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic              busDir,
  output logic              rspValid,
  output logic [15:0]       rspData
);

  localparam int PAD_W = 23 - ADDR_W;

  logic [ADDR_W-1:0] addrReg;
  logic [15:0]       rxShift;
  logic [23:0]       byteAddr;
  logic [7:0]        singleByte;
  logic [7:0]        quadByte;
  logic [BEAT_W-1:0] quadBeat;
  logic              singleBit;

  assign byteAddr = {{PAD_W{1'b0}}, addrReg, 1'b0};
  assign quadBeat = stb.beat - BEAT_W'(CMD_BEATS);

  always_comb begin
    singleByte = stb.readFrame ? OP_QREAD : scriptByte(stb.frameSel, stb.beat[4:3]);
    singleBit  = singleByte[3'd7 - stb.beat[2:0]];
    case (quadBeat[4:1])
      4'd2:    quadByte = byteAddr[23:16];
      4'd3:    quadByte = byteAddr[15:8];
      4'd4:    quadByte = byteAddr[7:0];
      4'd6:    quadByte = MODE_BYTE;
      default: quadByte = 8'h00;
    endcase
  end

  always_comb begin
    case (stb.lane)
      LANE_SINGLE: begin
        ioOut = {3'b000, singleBit};
        ioOe  = 4'b0001;
      end
      LANE_QOUT: begin
        ioOut = quadBeat[0] ? quadByte[3:0] : quadByte[7:4];
        ioOe  = 4'b1111;
      end
      default: begin
        ioOut = 4'b0000;
        ioOe  = 4'b0000;
      end
    endcase
  end

  assign busDir = !((stb.lane == LANE_SINGLE) || (stb.lane == LANE_QOUT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      rxShift  <= '0;
      rspData  <= '0;
      rspValid <= 1'b0;
    end else begin
      rspValid <= stb.pushWord;
      if (stb.latchAddr) addrReg <= reqAddr;
      if (stb.shiftIn)   rxShift <= {rxShift[11:0], ioIn};
      if (stb.pushWord)  rspData <= rxShift;
    end
  end

endmodule

// File: rtl/qspi_word_fetch.sv
module qspi_word_fetch
  import qfetch_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int GAP_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              busy,
  output logic              rspValid,
  output logic [15:0]       rspData,
  output logic              flashCsN,
  output logic              flashSck,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  input  logic [3:0]        ioIn,
  output logic              busDir
);

  strobe_t stb;

  qfetch_ctrl #(.GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .busy     (busy),
    .csN      (flashCsN),
    .sck      (flashSck),
    .stb      (stb)
  );

  qfetch_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .ioIn     (ioIn),
    .ioOut    (ioOut),
    .ioOe     (ioOe),
    .busDir   (busDir),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

endmodule

// File: rtl/qfetch_chk.sv
module qfetch_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       rspValid,
  input logic       flashCsN,
  input logic       flashSck,
  input logic [3:0] ioOut,
  input logic [3:0] ioOe,
  input logic       busDir
);

  // R5
  dir_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDir == (ioOe == 4'b0000))
    else $error("direction pin disagrees with output enables");

  // R5
  turn_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busDir) && !flashCsN) |-> !flashSck)
    else $error("turnaround not on a falling clock edge");

  // R7
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashSck |-> !flashCsN)
    else $error("serial clock high outside a frame");

  // R7
  sck_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashSck |=> !flashSck)
    else $error("serial clock high for two clocks");

  // R7
  hold_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashSck |-> ($stable(ioOut) && $stable(ioOe)))
    else $error("data changed while serial clock high");

  // R8
  frame_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashCsN) |-> !flashSck)
    else $error("frame opened with serial clock high");

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> flashCsN)
    else $error("chip select low while not busy");

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid)
    else $error("response valid longer than one clock");

  // R9
  rsp_at_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (flashCsN && $rose(flashCsN) && busy))
    else $error("response not aligned to frame close");

endmodule

bind qspi_word_fetch qfetch_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .rspValid (rspValid),
  .flashCsN (flashCsN),
  .flashSck (flashSck),
  .ioOut    (ioOut),
  .ioOe     (ioOe),
  .busDir   (busDir)
);

// File: tb/sim_qspi_word_fetch.sv
module sim_qspi_word_fetch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [13:0] reqAddr = 14'h0;
  logic        busy;
  logic        rspValid;
  logic [15:0] rspData;
  logic        flashCsN;
  logic        flashSck;
  logic [3:0]  ioOut;
  logic [3:0]  ioOe;
  logic [3:0]  ioIn = 4'h0;
  logic        busDir;

  always #2 clk = ~clk;

  qspi_word_fetch u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .busy(busy), .rspValid(rspValid), .rspData(rspData),
    .flashCsN(flashCsN), .flashSck(flashSck), .ioOut(ioOut), .ioOe(ioOe),
    .ioIn(ioIn), .busDir(busDir)
  );

  int checks = 0;
  int failures = 0;
  int tick = 0;
  bit finished = 0;

  function automatic logic [7:0] memByte(input int b);
    return 8'((b * 29) + 7 + (b >> 8));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h tick=%0d", req, what, act, exp, tick);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // flash model and reference state
  bit          prevCs = 1;
  bit          prevSck = 0;
  logic [3:0]  prevOut = 4'h0;
  logic [3:0]  prevOe = 4'h0;
  int          frameNo = 0;
  int          beatN = 0;
  int          accBits = 0;
  logic [7:0]  acc = 8'h0;
  logic [7:0]  fb[$];
  bit          flashDrive = 0;
  int          csHighRun = 0;
  int          readFrames = 0;
  int          accepted = 0;
  int          responses = 0;
  bit          resetSeen = 0;
  logic [13:0] addrQ[$];
  int          dueQ[$];
  logic [15:0] wordQ[$];

  always @(negedge clk) begin
    tick++;
    if (tick > 20000) begin
      failures++;
      $display("FAIL watchdog expired tick=%0d", tick);
      summary();
    end
    if (!rstN) begin
      if (!resetSeen && tick > 2) begin
        resetSeen = 1;
        // R1
        check(flashCsN == 1 && flashSck == 0, "R1", {flashCsN, flashSck}, 2, "cs/sck in reset");
        check(ioOe == 4'h0 && busDir == 1, "R1", {ioOe, busDir}, 1, "oe/dir in reset");
        check(busy == 1 && rspValid == 0, "R1", {busy, rspValid}, 2, "busy/valid in reset");
      end
    end else begin
      // R5 direction tracks enables, no contention
      check(busDir == (ioOe == 4'h0), "R5", busDir, (ioOe == 4'h0), "direction vs enable");
      if (flashDrive) check(ioOe == 4'h0, "R5", ioOe, 0, "enable while flash drives");
      // R7 clock shape
      if (flashSck) begin
        check(!flashCsN, "R7", flashCsN, 0, "sck high outside frame");
        check(!prevSck, "R7", prevSck, 0, "sck high two clocks");
        check(ioOut == prevOut && ioOe == prevOe, "R7", ioOut, prevOut, "data moved while sck high");
      end
      // R3 no frame while idle
      if (!busy) check(flashCsN, "R3", flashCsN, 1, "cs low while not busy");
      // R2 only line 0 during script frames
      if (!flashCsN && frameNo < 4) check(ioOe == 4'b0001, "R2", ioOe, 1, "script enables");

      if (!flashCsN && prevCs) begin
        // R8
        check(csHighRun >= 1, "R8", csHighRun, 1, "cs high gap");
        beatN = 0; accBits = 0; fb.delete();
      end
      if (flashCsN) csHighRun++; else csHighRun = 0;

      if (!flashCsN) begin
        if (flashSck && !prevSck) begin
          if (frameNo < 4 || beatN < 8) begin
            acc = {acc[6:0], ioOut[0]}; accBits += 1;
          end else if (beatN < 22) begin
            acc = {acc[3:0], ioOut}; accBits += 4;
          end
          if (accBits == 8) begin fb.push_back(acc); accBits = 0; end
          beatN++;
        end
        if (!flashSck && prevSck && frameNo >= 4 && beatN >= 22 && beatN < 26) begin
          int a;
          logic [7:0] d;
          a = (fb.size() >= 6) ? {fb[3], fb[4], fb[5]} : 0;
          d = memByte(a + ((beatN - 22) / 2));
          ioIn = ((beatN - 22) % 2 == 0) ? d[7:4] : d[3:0];
          flashDrive = 1;
        end
      end else begin
        flashDrive = 0;
        if (!prevCs) begin
          if (frameNo < 4) begin
            // R2
            case (frameNo)
              0: check(fb.size() == 1 && fb[0] == 8'hFF, "R2", fb.size() > 0 ? fb[0] : 0, 8'hFF, "script frame 0");
              1: check(fb.size() == 1 && fb[0] == 8'hAB, "R2", fb.size() > 0 ? fb[0] : 0, 8'hAB, "script frame 1");
              2: check(fb.size() == 1 && fb[0] == 8'h06, "R2", fb.size() > 0 ? fb[0] : 0, 8'h06, "script frame 2");
              default: check(fb.size() == 3 && fb[0] == 8'h01 && fb[1] == 8'h02 && fb[2] == 8'h02,
                             "R2", fb.size(), 3, "script frame 3");
            endcase
          end else begin
            logic [23:0] b;
            readFrames++;
            // R8
            check(addrQ.size() > 0, "R8", readFrames, accepted, "frame without request");
            b = (addrQ.size() > 0) ? {9'd0, addrQ[0], 1'b0} : 24'h0;
            if (addrQ.size() > 0) void'(addrQ.pop_front());
            // R4
            check(fb.size() == 8, "R4", fb.size(), 8, "read frame length");
            if (fb.size() == 8) begin
              check(fb[0] == 8'hEB, "R4", fb[0], 8'hEB, "opcode");
              check(fb[1] == 8'h00 && fb[2] == 8'h00, "R4", {fb[1], fb[2]}, 0, "leading zero bytes");
              check({fb[3], fb[4], fb[5]} == b, "R4", {fb[3], fb[4], fb[5]}, b, "byte address");
              check(fb[6] == 8'h00 && fb[7] == 8'hA5, "R4", {fb[6], fb[7]}, 16'h00A5, "trailer bytes");
            end
          end
          frameNo++;
        end
      end

      // R9 / R6 response timing and content
      if (rspValid) begin
        responses++;
        check(dueQ.size() > 0 && dueQ[0] == tick, "R9", tick, dueQ.size() > 0 ? dueQ[0] : -1, "response tick");
        check(wordQ.size() > 0 && rspData == wordQ[0], "R6", rspData, wordQ.size() > 0 ? wordQ[0] : 0, "response word");
        if (dueQ.size() > 0) begin void'(dueQ.pop_front()); void'(wordQ.pop_front()); end
      end else if (dueQ.size() > 0 && dueQ[0] <= tick) begin
        check(0, "R9", 0, 1, "missing response");
        void'(dueQ.pop_front()); void'(wordQ.pop_front());
      end

      // acceptance seen by the reference
      if (reqValid && !busy) begin
        accepted++;
        addrQ.push_back(reqAddr);
        dueQ.push_back(tick + 53);
        wordQ.push_back({memByte(2 * int'(reqAddr)), memByte(2 * int'(reqAddr) + 1)});
      end
    end
    prevCs = flashCsN;
    prevSck = flashSck;
    prevOut = ioOut;
    prevOe = ioOe;
  end

  task automatic issue(input logic [13:0] a, input bit keep);
    @(posedge clk); #1;
    reqValid = 1; reqAddr = a;
    forever begin
      @(negedge clk);
      if (!busy) break;
    end
    @(posedge clk); #1;
    if (!keep) reqValid = 0;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1;
    // R3 stray request during start-up
    reqValid = 1; reqAddr = 14'h0AAA;
    repeat (30) @(posedge clk);
    #1 reqValid = 0;
    forever begin
      @(negedge clk);
      if (!busy) break;
    end
    @(posedge clk); #1;
    // R3
    check(frameNo == 4 && readFrames == 0, "R3", readFrames, 0, "frames after start-up");
    check(accepted == 0 && responses == 0, "R3", accepted, 0, "request taken while busy");

    issue(14'h0000, 0);
    issue(14'h3FFF, 0);
    issue(14'h1234, 1);
    issue(14'h2001, 0);
    issue(14'h0F0F, 0);
    // R3 stray request during a read
    repeat (10) @(posedge clk);
    #1 reqValid = 1; reqAddr = 14'h0555;
    repeat (20) @(posedge clk);
    #1 reqValid = 0;
    repeat (120) @(posedge clk);
    // R8 R3
    check(accepted == 5 && readFrames == 5, "R8", readFrames, 5, "one frame per request");
    check(responses == 5 && dueQ.size() == 0, "R3", responses, 5, "responses after stray request");
    summary();
  end

endmodule